// File: doc/BRIEF.md
# Dependent Micro-op Pair Fuser

This block takes a window of eight decoded micro-ops and decides which dependent pairs are fused into single macro-ops. Each op has a class, an optional destination register and up to two optional source registers. A head is always a single-cycle ALU op that produces a value. Its tail is a later op that reads that value. Every fused pair is reported two ways. The head gets a fusible bit. The tail gets a valid flag and the index of its head.

A window is loaded in one valid/ready beat. The block then works through the window twice, looking at one tail candidate per clock. In the first sweep only ALU ops may be tails. The second sweep, over what is still unpaired, lets any class be a tail. For each tail the block picks the nearest legal head before it. A done pulse marks the end of the work. The results stay on the outputs until the next window is accepted.

Top module: `mop_pair_fuser`

## Requirements
- R1: After reset `in_ready` is 1, `done` is 0 and `fus_bit`, `tail_vld` and `tail_head` are all zero.
- R2: A window is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 until the work ends. `done` is 1 for exactly the 17th cycle after the accepting edge, with `in_ready` still 0, and `in_ready` returns in the cycle after. Accepting a window clears all previous results. Results hold steady between `done` and the next accept.
- R3: A head must have class 0 (single-cycle ALU) and its destination-valid flag set. Class codes are 0 single-cycle ALU, 1 multi-cycle ALU, 2 memory and 3 branch.
- R4: A tail must have a valid source whose register equals the head's destination.
- R5: A pair is rejected if it names more than two distinct source registers. The count takes the head's valid sources and the tail's valid sources, leaving out any tail source equal to the head's destination.
- R6: In the first sweep only class 0 or class 1 entries are tail candidates. Memory and branch entries can become tails only in the second sweep.
- R7: When more than one head is legal for a tail, the one with the highest index below the tail is chosen.
- R8: An entry takes part in at most one pair. Once it is a head or a tail, it is neither head nor tail again.
- R9: A head is illegal if any entry strictly between head and tail does either of these: writes one of the head's sources or the head's destination, or reads the head's destination.
- R10: Head and tail need not be adjacent. A fused tail at entry i has `tail_vld[i]`=1 and `tail_head[3i+2:3i]` set to the head index, and its head j has `fus_bit[j]`=1. Entry i of `in_win` sits at bits [20i+19:20i] with this layout: class [19:18], destination valid [17], destination [16:12], source0 valid [11], source0 [10:6], source1 valid [5], source1 [4:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A window is offered |
| in_ready | output | 1 | Block is idle and takes a window |
| in_win | input | 160 | Eight packed micro-op entries |
| done | output | 1 | One-cycle pulse at the end of both sweeps |
| fus_bit | output | 8 | Per entry: entry is a fused head |
| tail_vld | output | 8 | Per entry: entry is a fused tail |
| tail_head | output | 24 | Per entry: 3-bit head index of that tail |

## Verification
Two events can fall in the same cycle here. The first is a first-sweep fusion on the last entry, which happens in the same cycle as the switch to the second sweep. A window whose entry 7 is an ALU tail provokes it, and a second-sweep memory tail in the same window must still be paired. The second is the done pulse arriving while a new window is already held on a steady `in_valid`. The bench judges this by checking that the new window is not taken during `done`, that the old results are intact during `done`, and that the new window is taken on the next edge and produces its own results.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  parameter int REG_W = 5;

  typedef enum logic [1:0] {
    OP_ALU1 = 2'd0,
    OP_ALUM = 2'd1,
    OP_MEM  = 2'd2,
    OP_BR   = 2'd3
  } opcls_t;

  typedef struct packed {
    opcls_t           cls;
    logic             dv;
    logic [REG_W-1:0] dst;
    logic             s0v;
    logic [REG_W-1:0] s0;
    logic             s1v;
    logic [REG_W-1:0] s1;
  } mop_t;

  localparam int ENT_W = $bits(mop_t);

  // number of distinct registers among up to four valid operands
  function automatic logic [2:0] src_count(input logic [3:0] v,
                                           input logic [3:0][REG_W-1:0] r);
    logic [2:0] c;
    logic dup;
    c = '0;
    for (int a = 0; a < 4; a++) begin
      dup = 1'b0;
      for (int b = 0; b < a; b++)
        if (v[b] && r[b] == r[a]) dup = 1'b1;
      if (v[a] && !dup) c = c + 3'd1;
    end
    return c;
  endfunction
endpackage

// File: rtl/fuse_head_finder.sv
module fuse_head_finder
  import fuse_pkg::*;
#(
  parameter int NENT = 8,
  localparam int IDX_W = $clog2(NENT)
) (
  input  mop_t             win [NENT],
  input  logic [NENT-1:0]  used,
  input  logic [IDX_W-1:0] tail,
  output logic             found,
  output logic [IDX_W-1:0] head
);
  mop_t       t;
  logic       ok, dep, hz;
  logic [2:0] nsrc;

  always_comb begin
    t     = win[tail];
    found = 1'b0;
    head  = '0;
    ok    = 1'b0;
    dep   = 1'b0;
    hz    = 1'b0;
    nsrc  = '0;
    // ascending scan: a later legal head overrides, so the nearest wins
    for (int j = 0; j < NENT; j++) begin
      if (j < int'(tail)) begin
        ok   = !used[j] && win[j].cls == OP_ALU1 && win[j].dv;
        dep  = (t.s0v && t.s0 == win[j].dst) || (t.s1v && t.s1 == win[j].dst);
        nsrc = src_count({t.s1v && t.s1 != win[j].dst, t.s0v && t.s0 != win[j].dst,
                          win[j].s1v, win[j].s0v},
                         {t.s1, t.s0, win[j].s1, win[j].s0});
        hz   = 1'b0;
        for (int k = 0; k < NENT; k++) begin
          if (k > j && k < int'(tail)) begin
            if (win[k].dv && ((win[j].s0v && win[k].dst == win[j].s0) ||
                              (win[j].s1v && win[k].dst == win[j].s1) ||
                              win[k].dst == win[j].dst))
              hz = 1'b1;
            if ((win[k].s0v && win[k].s0 == win[j].dst) ||
                (win[k].s1v && win[k].s1 == win[j].dst))
              hz = 1'b1;
          end
        end
        if (ok && dep && nsrc <= 3'd2 && !hz) begin
          found = 1'b1;
          head  = IDX_W'(j);
        end
      end
    end
  end
endmodule

// File: rtl/fuse_ctrl.sv
module fuse_ctrl #(
  parameter int NENT = 8,
  localparam int IDX_W = $clog2(NENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             load_en,
  output logic             scan_en,
  output logic             pass2,
  output logic [IDX_W-1:0] idx,
  output logic             done
);
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_DONE} st_t;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NENT - 1);

  st_t              st_q, st_d;
  logic             pass_q, pass_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign in_ready = (st_q == ST_IDLE);
  assign load_en  = in_valid && in_ready;
  assign scan_en  = (st_q == ST_SCAN);
  assign pass2    = pass_q;
  assign idx      = idx_q;
  assign done     = (st_q == ST_DONE);

  always_comb begin
    st_d   = st_q;
    pass_d = pass_q;
    idx_d  = idx_q;
    case (st_q)
      ST_IDLE: if (load_en) begin
        st_d   = ST_SCAN;
        pass_d = 1'b0;
        idx_d  = '0;
      end
      ST_SCAN: if (idx_q == LAST) begin
        idx_d = '0;
        if (pass_q) st_d = ST_DONE;
        else        pass_d = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pass_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      st_q   <= st_d;
      pass_q <= pass_d;
      idx_q  <= idx_d;
    end
  end

  // R2: done lasts a single cycle
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: an accepted window closes the input until the work ends
  a_r2_busy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> !in_ready);
  // R2: done only after the last entry of the second sweep
  a_r2_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(scan_en && pass2 && idx == LAST));
endmodule

// File: rtl/mop_pair_fuser.sv
module mop_pair_fuser
  import fuse_pkg::*;
#(
  parameter int NENT = 8,
  localparam int IDX_W = $clog2(NENT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [NENT*ENT_W-1:0] in_win,
  output logic                  done,
  output logic [NENT-1:0]       fus_bit,
  output logic [NENT-1:0]       tail_vld,
  output logic [NENT*IDX_W-1:0] tail_head
);
  logic [1:0] rsync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  logic             load_en, scan_en, pass2, found;
  logic [IDX_W-1:0] idx, head;

  fuse_ctrl #(.NENT(NENT)) i_ctrl (
    .clk(clk), .rst_n(rst_s_n), .in_valid(in_valid), .in_ready(in_ready),
    .load_en(load_en), .scan_en(scan_en), .pass2(pass2), .idx(idx), .done(done)
  );

  mop_t             win_q [NENT];
  logic [NENT-1:0]  used_q, used_d, fus_q, fus_d, tv_q, tv_d;
  logic [IDX_W-1:0] hidx_q [NENT];
  logic [IDX_W-1:0] hidx_d [NENT];
  logic             tail_ok, hit, upd_en;

  fuse_head_finder #(.NENT(NENT)) i_find (
    .win(win_q), .used(used_q), .tail(idx), .found(found), .head(head)
  );

  assign tail_ok = !used_q[idx] &&
                   (pass2 || win_q[idx].cls == OP_ALU1 || win_q[idx].cls == OP_ALUM);
  assign hit     = scan_en && tail_ok && found;
  assign upd_en  = load_en || hit;

  always_comb begin
    used_d = used_q;
    fus_d  = fus_q;
    tv_d   = tv_q;
    for (int i = 0; i < NENT; i++) hidx_d[i] = hidx_q[i];
    if (load_en) begin
      used_d = '0;
      fus_d  = '0;
      tv_d   = '0;
      for (int i = 0; i < NENT; i++) hidx_d[i] = '0;
    end else if (hit) begin
      used_d[idx]  = 1'b1;
      used_d[head] = 1'b1;
      fus_d[head]  = 1'b1;
      tv_d[idx]    = 1'b1;
      hidx_d[idx]  = head;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      used_q <= '0;
      fus_q  <= '0;
      tv_q   <= '0;
      for (int i = 0; i < NENT; i++) hidx_q[i] <= '0;
    end else if (upd_en) begin
      used_q <= used_d;
      fus_q  <= fus_d;
      tv_q   <= tv_d;
      for (int i = 0; i < NENT; i++) hidx_q[i] <= hidx_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (load_en)
      for (int i = 0; i < NENT; i++) win_q[i] <= in_win[i*ENT_W +: ENT_W];
  end

  assign fus_bit  = fus_q;
  assign tail_vld = tv_q;

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    assign tail_head[g*IDX_W +: IDX_W] = hidx_q[g];

    // R8: one role per entry
    a_r8_single_role: assert property (@(posedge clk) disable iff (!rst_s_n)
      !(fus_q[g] && tv_q[g]));
    // R3: heads are single-cycle ALU producers
    a_r3_head_class: assert property (@(posedge clk) disable iff (!rst_s_n)
      fus_q[g] |-> (win_q[g].cls == OP_ALU1 && win_q[g].dv));
    // R10: a tail points back to a marked head
    a_r10_head_link: assert property (@(posedge clk) disable iff (!rst_s_n)
      tv_q[g] |-> (hidx_q[g] < IDX_W'(g) && fus_q[hidx_q[g]]));
    // R4: a tail reads what its head writes
    a_r4_dependence: assert property (@(posedge clk) disable iff (!rst_s_n)
      tv_q[g] |-> ((win_q[g].s0v && win_q[g].s0 == win_q[hidx_q[g]].dst) ||
                   (win_q[g].s1v && win_q[g].s1 == win_q[hidx_q[g]].dst)));
  end

  // R6: first-sweep tails are ALU ops
  a_r6_sweep1_alu: assert property (@(posedge clk) disable iff (!rst_s_n)
    (hit && !pass2) |-> (win_q[idx].cls inside {OP_ALU1, OP_ALUM}));
  // R2: results do not move outside a sweep except on a load
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!scan_en && !load_en) |=> ($stable(fus_q) && $stable(tv_q)));
endmodule

// File: tb/test_mop_pair_fuser.sv
`timescale 1ns/1ps
module test_mop_pair_fuser;
  localparam int N = 8;
  localparam int EW = 20;
  localparam int W = N * EW;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_win = '0;
  logic         in_ready, done;
  logic [N-1:0] fus_bit, tail_vld;
  logic [3*N-1:0] tail_head;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mop_pair_fuser i_mop_pair_fuser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_win(in_win), .done(done), .fus_bit(fus_bit), .tail_vld(tail_vld),
    .tail_head(tail_head)
  );

  logic [EW-1:0] ent [N];

  function automatic logic [EW-1:0] mk(input int cls, input bit dv, input int dst,
                                       input bit s0v, input int s0,
                                       input bit s1v, input int s1);
    return {2'(cls), dv, 5'(dst), s0v, 5'(s0), s1v, 5'(s1)};
  endfunction

  function automatic logic [W-1:0] packw();
    logic [W-1:0] w;
    for (int i = 0; i < N; i++) w[i*EW +: EW] = ent[i];
    return w;
  endfunction

  task automatic clear_ents();
    for (int i = 0; i < N; i++) ent[i] = mk(3, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_window(input string req);
    @(negedge clk);
    in_win = packw();
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2", {req, " ready low while busy"}, int'(in_ready), 0);
    repeat (15) @(negedge clk);
    chk("R2", {req, " done not early"}, int'(done), 0);
    @(negedge clk);
    chk("R2", {req, " done on cycle 17"}, int'(done), 1);
    @(negedge clk);
    chk("R2", {req, " done single cycle"}, int'(done), 0);
    chk("R2", {req, " ready back"}, int'(in_ready), 1);
  endtask

  task automatic chk_res(input string req, input int fexp, input int texp);
    chk(req, "fus_bit", int'(fus_bit), fexp);
    chk(req, "tail_vld", int'(tail_vld), texp);
  endtask

  task automatic chk_head(input string req, input int t, input int hexp);
    chk(req, $sformatf("tail_head[%0d]", t), int'(tail_head[t*3 +: 3]), hexp);
  endtask

  task automatic t_reset();
    chk("R1", "ready after reset", int'(in_ready), 1);
    chk("R1", "done after reset", int'(done), 0);
    chk_res("R1", 0, 0);
    chk("R1", "tail_head after reset", int'(tail_head), 0);
  endtask

  task automatic t_basic();
    clear_ents();
    ent[0] = mk(0, 1, 1, 1, 2, 1, 3);
    ent[1] = mk(0, 1, 4, 1, 1, 0, 0);
    run_window("basic");
    chk_res("R10", 'h01, 'h02);
    chk_head("R10", 1, 0);
    repeat (3) @(negedge clk);
    chk_res("R2", 'h01, 'h02);   // held while idle
  endtask

  task automatic t_head_class();
    clear_ents();
    ent[0] = mk(2, 1, 1, 1, 2, 0, 0);
    ent[1] = mk(0, 1, 4, 1, 1, 0, 0);
    ent[2] = mk(1, 1, 5, 1, 6, 0, 0);
    ent[3] = mk(0, 1, 7, 1, 5, 0, 0);
    run_window("class");
    chk_res("R3", 0, 0);          // also shows the load cleared R2
  endtask

  task automatic t_dependence();
    clear_ents();
    ent[0] = mk(0, 1, 1, 1, 2, 0, 0);
    ent[1] = mk(0, 1, 3, 1, 4, 0, 1);
    run_window("dep");
    chk_res("R4", 0, 0);
  endtask

  task automatic t_src_limit();
    clear_ents();
    ent[0] = mk(0, 1, 1, 1, 2, 1, 3);
    ent[1] = mk(0, 1, 5, 1, 1, 1, 4);
    ent[2] = mk(0, 1, 10, 1, 11, 1, 12);
    ent[3] = mk(0, 1, 13, 1, 10, 1, 11);
    run_window("srcs");
    chk_res("R5", 'h04, 'h08);
    chk_head("R5", 3, 2);
  endtask

  task automatic t_sweeps();
    clear_ents();
    ent[0] = mk(0, 1, 1, 1, 2, 0, 0);
    ent[1] = mk(2, 1, 3, 1, 1, 0, 0);
    ent[2] = mk(0, 1, 4, 1, 5, 0, 0);
    ent[3] = mk(3, 0, 0, 1, 4, 0, 0);
    ent[4] = mk(0, 1, 6, 1, 7, 0, 0);
    ent[5] = mk(1, 1, 8, 1, 6, 0, 0);
    run_window("sweeps");
    chk_res("R6", 'h15, 'h2A);
    chk_head("R6", 1, 0);
    chk_head("R6", 3, 2);
    chk_head("R6", 5, 4);
  endtask

  task automatic t_nearest();
    clear_ents();
    ent[0] = mk(0, 1, 1, 1, 2, 0, 0);
    ent[1] = mk(0, 1, 5, 1, 6, 0, 0);
    ent[2] = mk(0, 1, 7, 1, 1, 1, 5);
    run_window("nearest");
    chk_res("R7", 'h02, 'h04);
    chk_head("R7", 2, 1);
  endtask

  task automatic t_one_pair();
    clear_ents();
    ent[0] = mk(0, 1, 1, 1, 2, 0, 0);
    ent[1] = mk(0, 1, 3, 1, 1, 0, 0);
    ent[2] = mk(0, 1, 4, 1, 3, 0, 0);
    run_window("once");
    chk_res("R8", 'h01, 'h02);
    chk_head("R8", 1, 0);
  endtask

  task automatic t_hazard();
    clear_ents();
    ent[0] = mk(0, 1, 1, 1, 2, 0, 0);
    ent[1] = mk(0, 1, 2, 1, 9, 0, 0);
    ent[2] = mk(0, 1, 3, 1, 1, 0, 0);
    ent[3] = mk(0, 1, 10, 1, 11, 0, 0);
    ent[4] = mk(3, 0, 0, 1, 10, 0, 0);
    ent[5] = mk(0, 1, 12, 1, 10, 0, 0);
    run_window("hazard");
    chk_res("R9", 'h08, 'h10);
    chk_head("R9", 4, 3);
  endtask

  task automatic t_far();
    clear_ents();
    ent[0] = mk(0, 1, 1, 1, 2, 0, 0);
    ent[5] = mk(0, 1, 14, 1, 15, 0, 0);
    ent[6] = mk(2, 0, 0, 1, 1, 1, 3);
    ent[7] = mk(0, 1, 16, 1, 14, 0, 0);
    run_window("far");
    chk_res("R10", 'h21, 'hC0);
    chk_head("R10", 6, 0);
    chk_head("R10", 7, 5);
  endtask

  task automatic t_overlap();
    logic [W-1:0] wb;
    clear_ents();
    ent[3] = mk(0, 1, 20, 1, 21, 0, 0);
    ent[4] = mk(0, 1, 22, 1, 20, 0, 0);
    wb = packw();
    clear_ents();
    ent[0] = mk(0, 1, 1, 1, 2, 1, 3);
    ent[1] = mk(0, 1, 4, 1, 1, 0, 0);
    @(negedge clk);
    in_win = packw();
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_win = wb;
    chk("R2", "overlap busy", int'(in_ready), 0);
    repeat (15) @(negedge clk);
    @(negedge clk);
    chk("R2", "overlap done", int'(done), 1);
    chk("R2", "overlap not taken during done", int'(in_ready), 0);
    chk_res("R2", 'h01, 'h02);
    @(negedge clk);
    chk("R2", "overlap ready after done", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2", "second window taken", int'(in_ready), 0);
    repeat (15) @(negedge clk);
    @(negedge clk);
    chk("R2", "second done", int'(done), 1);
    chk_res("R2", 'h08, 'h10);
    chk_head("R2", 4, 3);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_head_class();
    t_dependence();
    t_src_limit();
    t_sweeps();
    t_nearest();
    t_one_pair();
    t_hazard();
    t_far();
    t_overlap();
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule